// File: doc/BRIEF.md
# Hybrid Circuit/Packet Output Port

This block is the output side of one mesh router port whose link is shared by two kinds of traffic. Circuit flits cross the router in a single registered stage. To do so, the circuit plane named by the flit must hold a live configuration that selects the flit's input port. Packet flits, and circuit flits that find no live configuration, take a buffered path of three stages: a buffer-write register, an allocation stage that holds a small FIFO, and the link register. The allocation stage may place a waiting flit on the link in any cycle in which no circuit flit claims it. This lets packet traffic use the idle bandwidth of established circuits without ever delaying them.

The per-plane configurations are written by a narrow setup channel. A setup message names a plane, an input port and a 4-bit destination, and can also carry a release flag that tears the plane down. The channel has no flow control and no virtual channels, and it never waits for an acknowledgement. A setup takes effect in the same cycle it arrives, so the first data flit can ride along with its own setup. A setup aimed at a plane that is already in use simply replaces the old entry.

Top module: `hcs_output_port`

## Requirements
- R1: After reset the link is idle (`link_valid`=0), `ps_ready`=1, and every plane is unconfigured, so a circuit flit sent right after reset is handled as packet traffic.
- R2: A circuit flit from input i whose plane p holds a live entry selecting i appears on the link one clock edge later, with `link_circuit`=1, `link_plane`=p, `link_dest` equal to the stored destination, and its data unchanged.
- R3: A packet flit accepted (`ps_valid` and `ps_ready`) on an idle port appears on the link three edges later with `link_circuit`=0, and not earlier. The link carries nothing in a cycle where neither a circuit flit wins nor a buffered flit is sent.
- R4: A winning circuit flit always takes the link. A buffered flit waits and leaves on the first edge at which no circuit flit wins.
- R5: A setup message carries a plane field of $clog2(NUM_PLANES) bits (2 by default), an input select and a 4-bit destination. It governs circuit flits that arrive in the same cycle as the setup itself.
- R6: A setup to a plane that is already configured replaces the input select and the destination together. The previously selected input no longer matches that plane.
- R7: A setup with `setup_release`=1 invalidates the plane. Later flits on it are handled as packet traffic.
- R8: A circuit flit whose plane is not live, or whose plane selects another input, is sent down the packet path. It appears three edges later with `link_circuit`=0 and the same data.
- R9: When several circuit flits match in one cycle, the one on the lowest-numbered plane wins and the others go down the packet path. Flits written to the buffer in one cycle are ordered by input index ascending, and the packet input comes last. The buffer is first-in first-out.
- R10: `ps_ready` is 1 exactly when held flits + flits in the buffer-write stage + NUM_IN + 1 ≤ DEPTH. With the link busy with circuit flits in every cycle, exactly DEPTH−NUM_IN packet flits are accepted starting from empty, and they later leave in order. Diverted flits that find the buffer full are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_valid | input | NUM_IN | Circuit flit present, one bit per input port |
| cs_plane | input | NUM_IN*PLANE_W | Plane number of each input's circuit flit |
| cs_data | input | NUM_IN*FLIT_W | Payload of each input's circuit flit |
| ps_valid | input | 1 | Packet flit offered |
| ps_data | input | FLIT_W | Packet flit payload |
| ps_ready | output | 1 | Packet flit will be accepted this cycle |
| setup_valid | input | 1 | Setup message present |
| setup_release | input | 1 | Setup tears the plane down |
| setup_plane | input | PLANE_W | Plane addressed by the setup |
| setup_inport | input | PORT_W | Input port the plane connects to this output |
| setup_dest | input | DEST_W | Destination stored with the circuit |
| link_valid | output | 1 | Link carries a flit |
| link_circuit | output | 1 | Link flit travelled as a circuit flit |
| link_plane | output | PLANE_W | Plane of a circuit flit, zero for packet flits |
| link_dest | output | DEST_W | Stored destination of a circuit flit, zero for packet flits |
| link_data | output | FLIT_W | Link payload |

## Verification
A circuit flit that wins is due on the link one edge after it is presented. A packet flit, or a circuit flit that finds no live entry, is due three edges after it is presented, provided no circuit traffic blocks it. Each extra cycle of circuit traffic delays it by one edge. The bench drives every input one nanosecond after a rising edge and reads the outputs at the same point after each following edge. It checks the intermediate edges for an idle link as well as the edge on which the result is due, so a result that comes too early or too late is reported. The sweeps vary plane, input, replacement and release, and the expected link contents are computed from the plane and input numbers.

// File: rtl/hcs_pkg.sv
`timescale 1ns/1ps
package hcs_pkg;

  // Position in a circular buffer reached by stepping off slots from base.
  function automatic int ring_slot(input int base, input int off, input int depth);
    return (base + off) % depth;
  endfunction

  // Packet input may be accepted when the worst-case next fill still fits:
  // held entries, entries in the write stage, one diversion per input and
  // the packet itself.
  function automatic logic room_for_packet(input int held, input int pending,
                                           input int n_in, input int depth);
    return (held + pending + n_in + 1) <= depth;
  endfunction

endpackage

// File: rtl/hcs_circuit_table.sv
`timescale 1ns/1ps
module hcs_circuit_table #(
  parameter int NUM_PLANES = 4,
  parameter int PORT_W     = 2,
  parameter int DEST_W     = 4,
  localparam int PLANE_W   = $clog2(NUM_PLANES)
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 setup_valid,
  input  logic                                 setup_release,
  input  logic [PLANE_W-1:0]                   setup_plane,
  input  logic [PORT_W-1:0]                    setup_inport,
  input  logic [DEST_W-1:0]                    setup_dest,
  output logic [NUM_PLANES-1:0]                eff_valid,
  output logic [NUM_PLANES-1:0][PORT_W-1:0]    eff_inport,
  output logic [NUM_PLANES-1:0][DEST_W-1:0]    eff_dest
);

  logic [NUM_PLANES-1:0]             cfg_live;
  logic [NUM_PLANES-1:0][PORT_W-1:0] cfg_port;
  logic [NUM_PLANES-1:0][DEST_W-1:0] cfg_dest;

  for (genvar p = 0; p < NUM_PLANES; p++) begin : g_plane
    logic hit;
    assign hit = setup_valid && (setup_plane == PLANE_W'(p));

    // Whole entry replaced in one edge.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_live[p] <= 1'b0;
        cfg_port[p] <= '0;
        cfg_dest[p] <= '0;
      end else if (hit) begin
        cfg_live[p] <= !setup_release;
        cfg_port[p] <= setup_inport;
        cfg_dest[p] <= setup_dest;
      end
    end

    // A setup steers flits of its own cycle: no wait for the stored copy.
    assign eff_valid[p]  = hit ? !setup_release : cfg_live[p];
    assign eff_inport[p] = hit ? setup_inport   : cfg_port[p];
    assign eff_dest[p]   = hit ? setup_dest     : cfg_dest[p];
  end

endmodule

// File: rtl/hcs_circuit_arb.sv
`timescale 1ns/1ps
module hcs_circuit_arb #(
  parameter int NUM_IN     = 4,
  parameter int NUM_PLANES = 4,
  localparam int PORT_W    = $clog2(NUM_IN),
  localparam int PLANE_W   = $clog2(NUM_PLANES)
) (
  input  logic [NUM_IN-1:0]                  cs_valid,
  input  logic [NUM_IN*PLANE_W-1:0]          cs_plane,
  input  logic [NUM_PLANES-1:0]              eff_valid,
  input  logic [NUM_PLANES-1:0][PORT_W-1:0]  eff_inport,
  output logic [NUM_IN-1:0]                  win_vec,
  output logic [NUM_IN-1:0]                  divert,
  output logic                               win_any,
  output logic [PORT_W-1:0]                  win_idx,
  output logic [PLANE_W-1:0]                 win_plane
);

  logic [NUM_IN-1:0] match;
  logic              found;

  always_comb begin
    logic [PLANE_W-1:0] pl;
    pl        = '0;
    found     = 1'b0;
    win_idx   = '0;
    win_plane = '0;
    match     = '0;
    for (int i = 0; i < NUM_IN; i++) begin
      pl       = cs_plane[i*PLANE_W +: PLANE_W];
      match[i] = cs_valid[i] && eff_valid[pl] && (eff_inport[pl] == PORT_W'(i));
      if (match[i] && (!found || pl < win_plane)) begin
        found     = 1'b1;
        win_plane = pl;
        win_idx   = PORT_W'(i);
      end
    end
  end

  assign win_any = found;
  assign win_vec = found ? (NUM_IN'(1) << win_idx) : '0;
  assign divert  = cs_valid & ~win_vec;

endmodule

// File: rtl/hcs_packet_path.sv
`timescale 1ns/1ps
module hcs_packet_path #(
  parameter int NUM_IN   = 4,
  parameter int FLIT_W   = 16,
  parameter int DEPTH    = 8,
  localparam int PTR_W   = $clog2(DEPTH),
  localparam int CNT_W   = $clog2(DEPTH + 1),
  localparam int SLOTS   = NUM_IN + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ps_valid,
  input  logic [FLIT_W-1:0]        ps_data,
  output logic                     ps_ready,
  input  logic [NUM_IN-1:0]        divert,
  input  logic [NUM_IN*FLIT_W-1:0] cs_data,
  input  logic                     link_taken,
  output logic                     pop,
  output logic [FLIT_W-1:0]        head_data,
  output logic [CNT_W-1:0]         count
);

  // Stage 1: buffer write register, one slot per source.
  logic [SLOTS-1:0]             slot_v;
  logic [SLOTS-1:0][FLIT_W-1:0] slot_d;

  // Stage 2: allocation FIFO.
  logic [FLIT_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  rd_ptr, wr_ptr;

  logic [SLOTS-1:0]            push_en;
  logic [SLOTS-1:0][PTR_W-1:0] push_idx;
  logic [CNT_W-1:0]            count_nxt;
  int                          pushed;
  logic                        ps_acc;

  assign ps_ready  = hcs_pkg::room_for_packet(int'(count), $countones(slot_v), NUM_IN, DEPTH);
  assign ps_acc    = ps_valid && ps_ready;
  assign head_data = mem[rd_ptr];

  always_comb begin
    int n;
    int off;
    pop = (count != '0) && !link_taken;
    n   = int'(count) - (pop ? 1 : 0);
    off = 0;
    for (int k = 0; k < SLOTS; k++) begin
      push_en[k]  = 1'b0;
      push_idx[k] = '0;
      if (slot_v[k] && n < DEPTH) begin
        push_en[k]  = 1'b1;
        push_idx[k] = PTR_W'(hcs_pkg::ring_slot(int'(wr_ptr), off, DEPTH));
        off = off + 1;
        n   = n + 1;
      end
    end
    pushed    = off;
    count_nxt = CNT_W'(n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_v <= '0;
      count  <= '0;
      rd_ptr <= '0;
      wr_ptr <= '0;
    end else begin
      slot_v <= {ps_acc, divert};
      count  <= count_nxt;
      wr_ptr <= PTR_W'(hcs_pkg::ring_slot(int'(wr_ptr), pushed, DEPTH));
      if (pop) rd_ptr <= PTR_W'(hcs_pkg::ring_slot(int'(rd_ptr), 1, DEPTH));
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < NUM_IN; k++) slot_d[k] <= cs_data[k*FLIT_W +: FLIT_W];
    slot_d[NUM_IN] <= ps_data;
    for (int k = 0; k < SLOTS; k++) begin
      if (push_en[k]) mem[push_idx[k]] <= slot_d[k];
    end
  end

endmodule

// File: rtl/hcs_output_port.sv
`timescale 1ns/1ps
module hcs_output_port #(
  parameter int NUM_IN     = 4,
  parameter int NUM_PLANES = 4,
  parameter int FLIT_W     = 16,
  parameter int DEST_W     = 4,
  parameter int DEPTH      = 8,
  localparam int PORT_W    = $clog2(NUM_IN),
  localparam int PLANE_W   = $clog2(NUM_PLANES),
  localparam int CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_IN-1:0]         cs_valid,
  input  logic [NUM_IN*PLANE_W-1:0] cs_plane,
  input  logic [NUM_IN*FLIT_W-1:0]  cs_data,
  input  logic                      ps_valid,
  input  logic [FLIT_W-1:0]         ps_data,
  output logic                      ps_ready,
  input  logic                      setup_valid,
  input  logic                      setup_release,
  input  logic [PLANE_W-1:0]        setup_plane,
  input  logic [PORT_W-1:0]         setup_inport,
  input  logic [DEST_W-1:0]         setup_dest,
  output logic                      link_valid,
  output logic                      link_circuit,
  output logic [PLANE_W-1:0]        link_plane,
  output logic [DEST_W-1:0]         link_dest,
  output logic [FLIT_W-1:0]         link_data
);

  if (!(NUM_PLANES == 2 || NUM_PLANES == 4)) begin : g_bad_planes
    $error("hcs_output_port: NUM_PLANES must be 2 or 4");
  end

  logic [NUM_PLANES-1:0]             eff_valid;
  logic [NUM_PLANES-1:0][PORT_W-1:0] eff_inport;
  logic [NUM_PLANES-1:0][DEST_W-1:0] eff_dest;

  logic [NUM_IN-1:0]  win_vec;
  logic [NUM_IN-1:0]  divert;
  logic               win_any;
  logic [PORT_W-1:0]  win_idx;
  logic [PLANE_W-1:0] win_plane;

  logic               pkt_pop;
  logic [FLIT_W-1:0]  pkt_head;
  logic [CNT_W-1:0]   pkt_count;

  hcs_circuit_table #(
    .NUM_PLANES(NUM_PLANES), .PORT_W(PORT_W), .DEST_W(DEST_W)
  ) u_table (
    .clk(clk), .rst_n(rst_n),
    .setup_valid(setup_valid), .setup_release(setup_release),
    .setup_plane(setup_plane), .setup_inport(setup_inport), .setup_dest(setup_dest),
    .eff_valid(eff_valid), .eff_inport(eff_inport), .eff_dest(eff_dest)
  );

  hcs_circuit_arb #(
    .NUM_IN(NUM_IN), .NUM_PLANES(NUM_PLANES)
  ) u_arb (
    .cs_valid(cs_valid), .cs_plane(cs_plane),
    .eff_valid(eff_valid), .eff_inport(eff_inport),
    .win_vec(win_vec), .divert(divert), .win_any(win_any),
    .win_idx(win_idx), .win_plane(win_plane)
  );

  hcs_packet_path #(
    .NUM_IN(NUM_IN), .FLIT_W(FLIT_W), .DEPTH(DEPTH)
  ) u_pkt (
    .clk(clk), .rst_n(rst_n),
    .ps_valid(ps_valid), .ps_data(ps_data), .ps_ready(ps_ready),
    .divert(divert), .cs_data(cs_data), .link_taken(win_any),
    .pop(pkt_pop), .head_data(pkt_head), .count(pkt_count)
  );

  // Stage 3 / circuit stage: the link register.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      link_valid   <= 1'b0;
      link_circuit <= 1'b0;
      link_plane   <= '0;
      link_dest    <= '0;
      link_data    <= '0;
    end else if (win_any) begin
      link_valid   <= 1'b1;
      link_circuit <= 1'b1;
      link_plane   <= win_plane;
      link_dest    <= eff_dest[win_plane];
      link_data    <= cs_data[int'(win_idx)*FLIT_W +: FLIT_W];
    end else if (pkt_pop) begin
      link_valid   <= 1'b1;
      link_circuit <= 1'b0;
      link_plane   <= '0;
      link_dest    <= '0;
      link_data    <= pkt_head;
    end else begin
      link_valid   <= 1'b0;
      link_circuit <= 1'b0;
    end
  end

endmodule

// File: rtl/hcs_output_port_chk.sv
`timescale 1ns/1ps
module hcs_output_port_chk #(
  parameter int NUM_IN = 4,
  parameter int DEPTH  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NUM_IN-1:0] win_vec,
  input logic              win_any,
  input logic              pkt_pop,
  input logic [CNT_W-1:0]  pkt_count,
  input logic              link_valid,
  input logic              link_circuit
);

  assert_one_winner_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_vec));

  assert_circuit_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    win_any |=> (link_valid && link_circuit));

  assert_no_steal_under_circuit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_pop |-> !win_any);

  assert_packet_on_link_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_pop |=> (link_valid && !link_circuit));

  assert_idle_link_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_any && !pkt_pop) |=> !link_valid);

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_count <= CNT_W'(DEPTH));

endmodule

bind hcs_output_port hcs_output_port_chk #(.NUM_IN(NUM_IN), .DEPTH(DEPTH)) i_chk (
  .clk(clk), .rst_n(rst_n), .win_vec(win_vec), .win_any(win_any),
  .pkt_pop(pkt_pop), .pkt_count(pkt_count),
  .link_valid(link_valid), .link_circuit(link_circuit)
);

// File: tb/test_hcs_output_port.sv
`timescale 1ns/1ps
module test_hcs_output_port;
  localparam int NI = 4;
  localparam int NP = 4;
  localparam int FW = 16;
  localparam int DW = 4;
  localparam int DP = 8;
  localparam int PW = 2;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NI-1:0]    cs_valid = '0;
  logic [NI*PW-1:0] cs_plane = '0;
  logic [NI*FW-1:0] cs_data  = '0;
  logic             ps_valid = 1'b0;
  logic [FW-1:0]    ps_data  = '0;
  logic             ps_ready;
  logic             setup_valid = 1'b0, setup_release = 1'b0;
  logic [PW-1:0]    setup_plane = '0;
  logic [IW-1:0]    setup_inport = '0;
  logic [DW-1:0]    setup_dest = '0;
  logic             link_valid, link_circuit;
  logic [PW-1:0]    link_plane;
  logic [DW-1:0]    link_dest;
  logic [FW-1:0]    link_data;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  hcs_output_port #(.NUM_IN(NI), .NUM_PLANES(NP), .FLIT_W(FW), .DEST_W(DW), .DEPTH(DP)) i_hcs_output_port (
    .clk(clk), .rst_n(rst_n), .cs_valid(cs_valid), .cs_plane(cs_plane), .cs_data(cs_data),
    .ps_valid(ps_valid), .ps_data(ps_data), .ps_ready(ps_ready),
    .setup_valid(setup_valid), .setup_release(setup_release), .setup_plane(setup_plane),
    .setup_inport(setup_inport), .setup_dest(setup_dest),
    .link_valid(link_valid), .link_circuit(link_circuit), .link_plane(link_plane),
    .link_dest(link_dest), .link_data(link_data));

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_idle(input string req);
    chk(req, {31'd0, link_valid}, 32'd0);
  endtask

  task automatic chk_circ(input string req, input int pl, input int dst, input logic [FW-1:0] d);
    chk(req, {8'd0, link_valid, link_circuit, link_plane, link_dest, link_data},
        {8'd0, 1'b1, 1'b1, PW'(pl), DW'(dst), d});
  endtask

  task automatic chk_pkt(input string req, input logic [FW-1:0] d);
    chk(req, {8'd0, link_valid, link_circuit, link_plane, link_dest, link_data},
        {8'd0, 1'b1, 1'b0, PW'(0), DW'(0), d});
  endtask

  task automatic put_cs(input int i, input int pl, input logic [FW-1:0] d);
    cs_valid[i] = 1'b1;
    cs_plane[i*PW +: PW] = PW'(pl);
    cs_data[i*FW +: FW] = d;
  endtask

  task automatic clear_in();
    cs_valid = '0;
    ps_valid = 1'b0;
    setup_valid = 1'b0;
    setup_release = 1'b0;
  endtask

  task automatic put_setup(input int pl, input int ip, input int dst, input bit rel);
    setup_valid = 1'b1;
    setup_release = rel;
    setup_plane = PW'(pl);
    setup_inport = IW'(ip);
    setup_dest = DW'(dst);
  endtask

  task automatic do_setup(input int pl, input int ip, input int dst, input bit rel);
    put_setup(pl, ip, dst, rel);
    step();
    clear_in();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int acc;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    step();
    // R1: reset state
    chk_idle("R1 link idle after reset");
    chk("R1 ps_ready after reset", {31'd0, ps_ready}, 32'd1);
    // R1/R8: no plane live -> flit handled as packet traffic
    put_cs(0, 0, 16'hA0A0);
    step(); clear_in();
    chk_idle("R1 unconfigured plane gives no circuit");
    step(); chk_idle("R8 diverted flit not early");
    step(); chk_pkt("R8 diverted flit after reset", 16'hA0A0);

    // R2/R6/R8 sweep over plane and input
    for (int p = 0; p < NP; p++) begin
      for (int i = 0; i < NI; i++) begin
        do_setup(p, i, (p * 5 + i) % 16, 1'b0);
        put_cs(i, p, FW'(16'hC000 + p * 16 + i));
        step(); clear_in();
        chk_circ("R2 circuit flit one edge later", p, (p * 5 + i) % 16, FW'(16'hC000 + p * 16 + i));
        put_cs((i + NI - 1) % NI, p, FW'(16'hD000 + p * 16 + i));
        step(); clear_in();
        chk_idle("R6 replaced or other input gets no circuit");
        step(); chk_idle("R8 diverted flit not early");
        step(); chk_pkt("R8 diverted flit as packet", FW'(16'hD000 + p * 16 + i));
      end
    end

    // R5: setup and first flit in the same cycle
    put_setup(2, 1, 9, 1'b0);
    put_cs(1, 2, 16'h5E75);
    step(); clear_in();
    chk_circ("R5 same-cycle setup carries flit", 2, 9, 16'h5E75);

    // R7: release tears the plane down
    do_setup(2, 1, 0, 1'b1);
    put_cs(1, 2, 16'h7E1E);
    step(); clear_in();
    chk_idle("R7 released plane gives no circuit");
    step(); step();
    chk_pkt("R7 flit on released plane as packet", 16'h7E1E);

    // R3: packet latency on an idle port
    chk("R3 ready before packet", {31'd0, ps_ready}, 32'd1);
    ps_valid = 1'b1; ps_data = 16'h3333;
    step(); clear_in();
    chk_idle("R3 packet not after one edge");
    step(); chk_idle("R3 packet not after two edges");
    step(); chk_pkt("R3 packet after three edges", 16'h3333);
    step(); chk_idle("R3 link idle afterwards");

    // R4: packet waits behind five circuit flits, then steals the gap
    do_setup(0, 0, 4, 1'b0);
    ps_valid = 1'b1; ps_data = 16'h4444;
    for (int c = 0; c < 5; c++) begin
      put_cs(0, 0, FW'(16'hB000 + c));
      step();
      ps_valid = 1'b0;
      chk_circ("R4 circuit keeps the link", 0, 4, FW'(16'hB000 + c));
    end
    clear_in();
    step(); chk_pkt("R4 packet in first free cycle", 16'h4444);

    // R9: two matching circuits, one mismatch and a packet in one cycle
    do_setup(1, 2, 6, 1'b0);
    do_setup(3, 0, 7, 1'b0);
    put_cs(0, 3, 16'h9000);
    put_cs(1, 0, 16'h9001);
    put_cs(2, 1, 16'h9002);
    ps_valid = 1'b1; ps_data = 16'h9004;
    step(); clear_in();
    chk_circ("R9 lowest plane wins", 1, 6, 16'h9002);
    step(); chk_idle("R9 losers not early");
    step(); chk_pkt("R9 order first input 0", 16'h9000);
    step(); chk_pkt("R9 order then input 1", 16'h9001);
    step(); chk_pkt("R9 order packet input last", 16'h9004);
    step(); chk_idle("R9 buffer drained");

    // R10: fill while circuits hold the link every cycle
    acc = 0;
    for (int c = 0; c < 12; c++) begin
      put_cs(0, 0, FW'(16'hE000 + c));
      ps_valid = ps_ready;
      ps_data = FW'(16'h5000 + acc);
      if (ps_ready) acc++;
      step();
    end
    chk("R10 packets accepted from empty", acc, DP - NI);
    chk("R10 ready low when full", {31'd0, ps_ready}, 32'd0);
    clear_in();
    for (int k = 0; k < DP - NI; k++) begin
      step();
      chk_pkt("R10 stored packets leave in order", FW'(16'h5000 + k));
    end
    step(); chk_idle("R10 buffer empty after drain");
    chk("R10 ready again", {31'd0, ps_ready}, 32'd1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule